// File: doc/BRIEF.md
# Buffer Read-Pointer Status Flags

This block follows the read position inside two small transmit buffers of a digital audio interface transmitter: a four-byte user-data area and a 24-byte channel-status area. Each consumed bit arrives as a one-cycle strobe. Eight strobes use up one byte and move the pointer on. When the pointer reaches the end of its area, it returns to the start of that area.

Two status flags tell the host which half of each buffer the transmitter is about to read, so the host knows which bytes it may rewrite. A byte counts as read (fetched) on the strobe that consumes its first bit. The user-data flag changes at the start of each byte pair. The channel-status flag is high while the first four bytes of the block are in use. An active-low interrupt pulse reports masked flag events: any change of the user-data flag, but only the rising edge of the channel-status flag.

Top module: `rdptr_flags`

## Requirements
- R1: While rst_ni is low, user_addr_o is 0x04, cs_addr_o is 0x08, flag0_o and flag2_o are 0, and irq_no is 1.
- R2: user_addr_o steps through 0x04, 0x05, 0x06, 0x07 and moves to the next address after every 8 strobes of user_bit_i. After 0x07 it returns to 0x04, so 32 strobes make one full cycle.
- R3: flag0_o goes to 0 on the strobe that fetches the byte at 0x04 and goes to 1 on the strobe that fetches the byte at 0x06. A byte is fetched by the first of its 8 strobes.
- R4: When mask0_i is 1, every change of flag0_o in either direction drives irq_no low. When mask0_i is 0, a change of flag0_o leaves irq_no high.
- R5: cs_addr_o steps from 0x08 to 0x1F and moves to the next address after every 8 strobes of cs_bit_i. After 0x1F it returns to 0x08, so 192 strobes make one block.
- R6: flag2_o goes to 1 on the strobe that fetches byte 0 (0x08) and goes to 0 on the strobe that fetches byte 4 (0x0C).
- R7: A rising edge of flag2_o drives irq_no low only when mask2_i is 1. A falling edge of flag2_o never drives irq_no low.
- R8: irq_no is low in exactly the one cycle in which a flag first shows its new value, and only if one of the masked events occurred. It returns high on the next cycle unless a new event happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| user_bit_i | input | 1 | Strobe: one user-data bit consumed |
| cs_bit_i | input | 1 | Strobe: one channel-status bit consumed |
| mask0_i | input | 1 | Interrupt enable for flag 0 changes |
| mask2_i | input | 1 | Interrupt enable for the flag 2 rising edge |
| flag0_o | output | 1 | User-data pair flag: 0 while the pair 0x04/0x05 is in use, 1 while the pair 0x06/0x07 is in use |
| flag2_o | output | 1 | High while channel-status bytes 0 to 3 are in use |
| user_addr_o | output | 8 | Current user-data read address |
| cs_addr_o | output | 8 | Current channel-status read address |
| irq_no | output | 1 | Interrupt pulse, active low |

## Verification
The bench drives complete pointer cycles past both wrap points: 32 user strobes and 192 channel-status strobes. A design that wraps one byte early or late would fetch the wrong address, and the reported address or the flag timing would then be off. The first fetch of 0x04 after reset must not interrupt, because flag0 is already low. A design that pulses on every fetch of 0x04, instead of on a real change, would fail that check. The falling edge of flag2 at byte 4 and each flag change with its mask cleared must leave irq_no high. The bench checks that irq_no is high again one cycle after each pulse, which catches a stretched interrupt or a latched one.

// File: rtl/rdptr_pkg.sv
package rdptr_pkg;
  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_RISE = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/rdptr_walker.sv
module rdptr_walker #(
  parameter int BASE   = 4,
  parameter int BYTES  = 4,
  parameter int BITS   = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_o
);
  localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE + BYTES - 1);
  localparam logic [CNT_W-1:0]  TOP   = CNT_W'(BITS - 1);

  logic [CNT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      addr_q <= FIRST;
    end else if (step_i) begin
      if (bit_q == TOP) begin
        bit_q  <= '0;
        addr_q <= (addr_q == LAST) ? FIRST : addr_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // first bit of a byte: the byte at addr_q is fetched
  assign fetch_o = step_i && (bit_q == '0);
  assign addr_o  = addr_q;
endmodule

// File: rtl/rdptr_flag.sv
module rdptr_flag
  import rdptr_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_ANY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic event_o
);
  logic flag_q, flag_d, rise, fall;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  assign rise = flag_d & ~flag_q;
  assign fall = ~flag_d & flag_q;

  generate
    if (MODE == EDGE_RISE) begin : g_rise
      assign event_o = mask_i & rise;
    end else begin : g_any
      assign event_o = mask_i & (rise | fall);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rdptr_flags.sv
module rdptr_flags
  import rdptr_pkg::*;
#(
  parameter int USER_BASE  = 4,
  parameter int USER_BYTES = 4,
  parameter int CS_BASE    = 8,
  parameter int CS_BYTES   = 24,
  parameter int CS_SPLIT   = 4,
  parameter int BITS       = 8,
  parameter int ADDR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              user_bit_i,
  input  logic              cs_bit_i,
  input  logic              mask0_i,
  input  logic              mask2_i,
  output logic              flag0_o,
  output logic              flag2_o,
  output logic [ADDR_W-1:0] user_addr_o,
  output logic [ADDR_W-1:0] cs_addr_o,
  output logic              irq_no
);
  localparam logic [ADDR_W-1:0] U_LO  = ADDR_W'(USER_BASE);
  localparam logic [ADDR_W-1:0] U_HI  = ADDR_W'(USER_BASE + USER_BYTES / 2);
  localparam logic [ADDR_W-1:0] C_TOP = ADDR_W'(CS_BASE);
  localparam logic [ADDR_W-1:0] C_MID = ADDR_W'(CS_BASE + CS_SPLIT);

  logic u_fetch, c_fetch, ev0, ev2, irq_q;

  rdptr_walker #(.BASE(USER_BASE), .BYTES(USER_BYTES), .BITS(BITS), .ADDR_W(ADDR_W)) u_user_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(user_bit_i),
    .addr_o(user_addr_o), .fetch_o(u_fetch)
  );

  rdptr_walker #(.BASE(CS_BASE), .BYTES(CS_BYTES), .BITS(BITS), .ADDR_W(ADDR_W)) u_cs_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(cs_bit_i),
    .addr_o(cs_addr_o), .fetch_o(c_fetch)
  );

  rdptr_flag #(.MODE(EDGE_ANY)) u_flag0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(u_fetch && user_addr_o == U_HI),
    .clr_i(u_fetch && user_addr_o == U_LO),
    .mask_i(mask0_i), .flag_o(flag0_o), .event_o(ev0)
  );

  rdptr_flag #(.MODE(EDGE_RISE)) u_flag2 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(c_fetch && cs_addr_o == C_TOP),
    .clr_i(c_fetch && cs_addr_o == C_MID),
    .mask_i(mask2_i), .flag_o(flag2_o), .event_o(ev2)
  );

  // pulse lands in the same cycle as the new flag value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else         irq_q <= ~(ev0 | ev2);
  end

  assign irq_no = irq_q;
endmodule

// File: rtl/rdptr_flags_chk.sv
module rdptr_flags_chk #(
  parameter int USER_BASE  = 4,
  parameter int USER_BYTES = 4,
  parameter int CS_BASE    = 8,
  parameter int CS_BYTES   = 24,
  parameter int ADDR_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              user_bit_i,
  input logic              cs_bit_i,
  input logic              mask0_i,
  input logic              mask2_i,
  input logic              flag0_o,
  input logic              flag2_o,
  input logic [ADDR_W-1:0] user_addr_o,
  input logic [ADDR_W-1:0] cs_addr_o,
  input logic              irq_no
);
  assert_user_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_addr_o >= ADDR_W'(USER_BASE) && user_addr_o <= ADDR_W'(USER_BASE + USER_BYTES - 1));

  assert_cs_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_addr_o >= ADDR_W'(CS_BASE) && cs_addr_o <= ADDR_W'(CS_BASE + CS_BYTES - 1));

  assert_flag0_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag0_o != $past(flag0_o)) |-> $past(user_bit_i));

  assert_flag2_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag2_o != $past(flag2_o)) |-> $past(cs_bit_i));

  assert_flag2_rise_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag2_o) |-> cs_addr_o == ADDR_W'(CS_BASE));

  assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> ((flag0_o != $past(flag0_o)) && $past(mask0_i)) ||
                ($rose(flag2_o) && $past(mask2_i)));

  assert_no_fall_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flag2_o) && flag0_o == $past(flag0_o)) |-> irq_no);

  assert_mask0_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag0_o != $past(flag0_o)) && $past(mask0_i)) |-> !irq_no);
endmodule

bind rdptr_flags rdptr_flags_chk #(
  .USER_BASE(USER_BASE), .USER_BYTES(USER_BYTES),
  .CS_BASE(CS_BASE), .CS_BYTES(CS_BYTES), .ADDR_W(ADDR_W)
) u_rdptr_flags_chk (.*);

// File: tb/rdptr_flags_bench.sv
module rdptr_flags_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       user_bit_i = 1'b0, cs_bit_i = 1'b0;
  logic       mask0_i = 1'b0, mask2_i = 1'b0;
  logic       flag0_o, flag2_o, irq_no;
  logic [7:0] user_addr_o, cs_addr_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rdptr_flags u_rdptr_flags (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    user_bit_i = 0; cs_bit_i = 0;
    @(negedge clk_i);
    chk("R1", "user_addr", user_addr_o, 8'h04);
    chk("R1", "cs_addr", cs_addr_o, 8'h08);
    chk("R1", "flag0", flag0_o, 0);
    chk("R1", "flag2", flag2_o, 0);
    chk("R1", "irq_n", irq_no, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic pulse(input logic u, input logic c);
    @(negedge clk_i); user_bit_i = u; cs_bit_i = c;
    @(negedge clk_i); user_bit_i = 0; cs_bit_i = 0;
  endtask

  // user-data walk over 40 strobes, flag0 interrupt with the given mask
  task automatic test_user(input logic m);
    int f0 = 0;
    do_reset();
    mask0_i = m;
    for (int n = 1; n <= 40; n++) begin
      int old_f = f0;
      int exp_irq;
      if ((n - 1) % 8 == 0) begin
        int idx = ((n - 1) / 8) % 4;
        if (idx == 0) f0 = 0;
        if (idx == 2) f0 = 1;
      end
      exp_irq = (m && f0 != old_f) ? 0 : 1;
      pulse(1'b1, 1'b0);
      chk("R2", "user_addr", user_addr_o, 4 + (n / 8) % 4);
      chk("R3", "flag0", flag0_o, f0);
      chk(m ? "R4" : "R4_mask_off", "irq_n", irq_no, exp_irq);
      if (exp_irq == 0) begin
        @(negedge clk_i);
        chk("R8", "irq_n one cycle", irq_no, 1);
      end
    end
    chk("R2", "cs_addr untouched", cs_addr_o, 8'h08);
  endtask

  // channel-status walk over 200 strobes, flag2 rising-edge interrupt
  task automatic test_cs(input logic m);
    int f2 = 0;
    do_reset();
    mask2_i = m;
    for (int n = 1; n <= 200; n++) begin
      int old_f = f2;
      int exp_irq;
      if ((n - 1) % 8 == 0) begin
        int idx = ((n - 1) / 8) % 24;
        if (idx == 0) f2 = 1;
        if (idx == 4) f2 = 0;
      end
      exp_irq = (m && f2 == 1 && old_f == 0) ? 0 : 1;
      pulse(1'b0, 1'b1);
      chk("R5", "cs_addr", cs_addr_o, 8 + (n / 8) % 24);
      chk("R6", "flag2", flag2_o, f2);
      chk("R7", "irq_n", irq_no, exp_irq);
      if (exp_irq == 0) begin
        @(negedge clk_i);
        chk("R8", "irq_n one cycle", irq_no, 1);
      end
    end
    chk("R5", "user_addr untouched", user_addr_o, 8'h04);
  endtask

  // both strobes together: first cs fetch rises flag2, user fetch of 0x04 keeps flag0
  task automatic test_both();
    do_reset();
    mask0_i = 1; mask2_i = 1;
    pulse(1'b1, 1'b1);
    chk("R8", "flag2", flag2_o, 1);
    chk("R8", "flag0", flag0_o, 0);
    chk("R8", "irq_n or", irq_no, 0);
    @(negedge clk_i);
    chk("R8", "irq_n release", irq_no, 1);
    for (int i = 0; i < 7; i++) pulse(1'b1, 1'b0);
    chk("R1", "pre-reset user_addr", user_addr_o, 8'h05);
    do_reset();
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    test_user(1'b1);
    test_user(1'b0);
    test_cs(1'b1);
    test_cs(1'b0);
    test_both();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule